// File: doc/BRIEF.md
# Digital Zero-Crossing Constant-Fraction Timing Discriminator

This block extracts an arrival time from a stream of signed, baseline-subtracted samples that arrive at one sample per clock. It does not search for the pulse peak. Instead it builds a bipolar signal by taking a shifted copy of the current sample and subtracting a sample that lies a programmable number of samples in the past. For pulses of the same shape, the point where this signal falls through zero does not depend on amplitude.

An amplitude threshold on the raw input arms the block. Once it is armed, the first falling zero crossing of the bipolar signal becomes an event. The block reports two things for that event. The coarse time is the free-running sample counter value of the last sample that had a positive bipolar value. The fine time is an 8-bit fraction of a sample, found by linear interpolation between the two samples on either side of the crossing and computed by a small sequential divider. After an event the block ignores the input for a programmable hold-off before it can arm again.

Top module: `zcfd_timer`

## Requirements
- R1: The bipolar value of sample k is z[k] = (x[k] >>> cfg_shift) − x[k−D]. Here D is cfg_delay, with legal values 1 to MAX_DLY. The shift is an arithmetic right shift, so it rounds toward minus infinity.
- R2: The block arms only on an accepted sample whose signed value is strictly greater than cfg_thresh. Zero crossings on samples before the arming sample never produce a result.
- R3: A crossing is an accepted sample with z ≤ 0 whose previous accepted sample had z > 0. A crossing on the arming sample itself counts as an event.
- R4: out_coarse equals the ts_count value that came with the accepted sample just before the crossing sample.
- R5: out_frac equals floor(256·z1/(z1−z2)), where z1 is the bipolar value before the crossing and z2 is the bipolar value at the crossing. out_valid is high for exactly one cycle. It rises on the 8th rising edge after the edge that accepts the crossing sample.
- R6: When z2 = 0, out_frac is 255, the largest code, and does not wrap to 0.
- R7: With a sample on every clock, an event on sample c with hold-off H (cfg_holdoff) means the first sample that can arm or cross again is c + max(H+2, 10).
- R8: After reset, out_valid is 0 and out_coarse is 0. Delay-line history reads as zero until D samples have been accepted.
- R9: A clock with in_valid low changes nothing: the delay line, the previous bipolar value, the previous time stamp and the hold-off count all keep their values, whatever in_data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample present this clock |
| in_data | input | DATA_W | Signed baseline-subtracted sample |
| ts_count | input | TS_W | Free-running sample counter |
| cfg_delay | input | $clog2(MAX_DLY+1) | Delay D in samples |
| cfg_shift | input | SHIFT_W | Fraction f = 2^-cfg_shift |
| cfg_thresh | input | DATA_W | Signed arming threshold |
| cfg_holdoff | input | HOLD_W | Samples ignored after an event |
| out_valid | output | 1 | One-cycle result strobe |
| out_coarse | output | TS_W | Time stamp of the sample before the crossing |
| out_frac | output | FRAC_W | Fine time in 1/256 sample |

## Verification
Arming on the threshold and accepting a zero crossing can happen on the same sample. The bench provokes this with a small lead-in that drives the bipolar value barely positive, followed by one large sample that both passes the threshold and pushes the bipolar value below zero. It then expects a single result with the interpolated fraction of 128.

A second case is the end of the hold-off window landing on the very sample that crosses. The bench sets up pulses spaced so that the re-arming sample is also the crossing sample, and it compares the number of events and their times against a reference computed from the requirements.

// File: rtl/zcfd_pkg.sv
// Shared types for the zero-crossing constant-fraction timing block.
package zcfd_pkg;
    typedef enum logic [1:0] {
        ST_ARMED  = 2'd0,   // waiting for a sample above threshold
        ST_SEARCH = 2'd1,   // armed, looking for the falling crossing
        ST_HOLD   = 2'd2    // event taken, input ignored
    } arm_state_t;
endpackage

// File: rtl/zcfd_bipolar.sv
// Bipolar signal former.
// Keeps the last MAX_DLY accepted samples and presents
//   z = (x >>> shift) - x[k-D]
// for the sample on in_data this cycle. Assumes cfg_delay lies in
// 1..MAX_DLY; any other value selects the oldest tap.
module zcfd_bipolar #(
    parameter int DATA_W  = 14,
    parameter int MAX_DLY = 8,
    parameter int DLY_W   = 4,
    parameter int SHIFT_W = 3,
    parameter int Z_W     = DATA_W + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic signed [DATA_W-1:0]  in_data,
    input  logic        [DLY_W-1:0]   cfg_delay,
    input  logic        [SHIFT_W-1:0] cfg_shift,
    output logic signed [Z_W-1:0]     z_cur
);
    logic signed [DATA_W-1:0] line_q [MAX_DLY];
    logic signed [DATA_W-1:0] tap;
    logic signed [DATA_W-1:0] scaled;

    // Delay line: shift on every accepted sample only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_DLY; i++) line_q[i] <= '0;
        end else if (in_valid) begin
            line_q[0] <= in_data;
            for (int i = 1; i < MAX_DLY; i++) line_q[i] <= line_q[i-1];
        end
    end

    // Tap select: one comparator per stage.
    always_comb begin
        tap = line_q[MAX_DLY-1];
        for (int j = 0; j < MAX_DLY; j++) begin
            if (cfg_delay == DLY_W'(j + 1)) tap = line_q[j];
        end
    end

    // Scale by a power of two and subtract the delayed sample.
    always_comb begin
        scaled = in_data >>> cfg_shift;
        z_cur  = Z_W'(scaled) - Z_W'(tap);
    end
endmodule

// File: rtl/zcfd_frac_div.sv
// Restoring divider for the interpolation fraction.
// Produces floor(2^Q_W * num / den) one quotient bit per clock and
// pulses done on the last step. Assumes 0 < num <= den at start;
// num == den then yields all ones. start is never given while busy.
module zcfd_frac_div #(
    parameter int IN_W = 16,
    parameter int Q_W  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [IN_W-1:0] num,
    input  logic [IN_W-1:0] den,
    output logic            busy,
    output logic            done,
    output logic [Q_W-1:0]  quot
);
    localparam int R_W   = IN_W + 1;
    localparam int CNT_W = $clog2(Q_W + 1);

    logic [R_W-1:0]   rem_q, den_q, rem_sh, rem_nx;
    logic [Q_W-1:0]   quot_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q, done_q, sat_q, ge;

    // One restoring step.
    always_comb begin
        rem_sh = {rem_q[R_W-2:0], 1'b0};
        ge     = (rem_sh >= den_q);
        rem_nx = ge ? (rem_sh - den_q) : rem_sh;
    end

    // Step sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            den_q  <= '0;
            quot_q <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            sat_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                rem_q  <= {1'b0, num};
                den_q  <= {1'b0, den};
                quot_q <= '0;
                cnt_q  <= CNT_W'(Q_W);
                busy_q <= 1'b1;
                sat_q  <= (num == den);
            end else if (busy_q) begin
                rem_q  <= rem_nx;
                quot_q <= {quot_q[Q_W-2:0], ge};
                cnt_q  <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign quot = quot_q;

    // R6: equal operands come out as the largest code.
    a_r6_saturated_code: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && sat_q) |-> (quot_q == {Q_W{1'b1}}));

    // R5: partial remainder never exceeds the divisor while stepping.
    a_r5_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (rem_q <= den_q));
endmodule

// File: rtl/zcfd_timer.sv
// Zero-crossing constant-fraction timing discriminator (top).
// Arms on a sample above cfg_thresh, takes the first falling zero
// crossing of the bipolar signal as the event, latches the time stamp
// of the last positive sample and interpolates a FRAC_W-bit fraction.
// After an event, it waits cfg_holdoff accepted samples and for the
// divider to finish before it re-arms. Assumes ts_count is supplied
// alongside each sample.
module zcfd_timer
    import zcfd_pkg::*;
#(
    parameter int DATA_W  = 14,
    parameter int TS_W    = 32,
    parameter int MAX_DLY = 8,
    parameter int SHIFT_W = 3,
    parameter int HOLD_W  = 8,
    parameter int FRAC_W  = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    input  logic signed [DATA_W-1:0]            in_data,
    input  logic        [TS_W-1:0]              ts_count,
    input  logic        [$clog2(MAX_DLY+1)-1:0] cfg_delay,
    input  logic        [SHIFT_W-1:0]           cfg_shift,
    input  logic signed [DATA_W-1:0]            cfg_thresh,
    input  logic        [HOLD_W-1:0]            cfg_holdoff,
    output logic                                out_valid,
    output logic        [TS_W-1:0]              out_coarse,
    output logic        [FRAC_W-1:0]            out_frac
);
    localparam int DLY_W  = $clog2(MAX_DLY + 1);
    localparam int Z_W    = DATA_W + 1;
    localparam int DIV_W  = Z_W + 1;

    arm_state_t               state_q;
    logic [HOLD_W-1:0]        hold_cnt_q;
    logic signed [Z_W-1:0]    z_cur, zprev_q;
    logic [TS_W-1:0]          tsprev_q, coarse_q;
    logic signed [DIV_W-1:0]  den_s;
    logic [DIV_W-1:0]         div_num, div_den;
    logic                     above, falling, eligible, div_start;
    logic                     div_busy, div_done;
    logic [FRAC_W-1:0]        div_quot;

    zcfd_bipolar #(
        .DATA_W (DATA_W),
        .MAX_DLY(MAX_DLY),
        .DLY_W  (DLY_W),
        .SHIFT_W(SHIFT_W),
        .Z_W    (Z_W)
    ) u_bipolar (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .cfg_delay(cfg_delay),
        .cfg_shift(cfg_shift),
        .z_cur    (z_cur)
    );

    // Event qualification for the sample on the input this cycle.
    always_comb begin
        above     = (in_data > cfg_thresh);
        falling   = (zprev_q > 0) && (z_cur <= 0);
        eligible  = (state_q == ST_SEARCH) || ((state_q == ST_ARMED) && above);
        div_start = in_valid && falling && eligible;
        den_s     = DIV_W'(zprev_q) - DIV_W'(z_cur);
        div_num   = DIV_W'(zprev_q);
        div_den   = den_s;
    end

    // Arming state, hold-off count and previous-sample history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_ARMED;
            hold_cnt_q <= '0;
            zprev_q    <= '0;
            tsprev_q   <= '0;
            coarse_q   <= '0;
        end else begin
            if (in_valid) begin
                zprev_q  <= z_cur;
                tsprev_q <= ts_count;
            end
            case (state_q)
                ST_ARMED:  if (in_valid && above) state_q <= div_start ? ST_HOLD : ST_SEARCH;
                ST_SEARCH: if (div_start) state_q <= ST_HOLD;
                ST_HOLD: begin
                    if (hold_cnt_q == '0 && !div_busy) state_q <= ST_ARMED;
                    else if (in_valid && hold_cnt_q != '0) hold_cnt_q <= hold_cnt_q - 1'b1;
                end
                default:   state_q <= ST_ARMED;
            endcase
            if (div_start) begin
                hold_cnt_q <= cfg_holdoff;
                coarse_q   <= tsprev_q;
            end
        end
    end

    zcfd_frac_div #(
        .IN_W(DIV_W),
        .Q_W (FRAC_W)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .start(div_start),
        .num  (div_num),
        .den  (div_den),
        .busy (div_busy),
        .done (div_done),
        .quot (div_quot)
    );

    assign out_valid  = div_done;
    assign out_coarse = coarse_q;
    assign out_frac   = div_quot;

    // R5: a new event never lands on a divide in progress.
    a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        div_start |-> !div_busy);

    // R5: the result strobe lasts a single cycle.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R7: hold-off is not left while the fraction is still being formed.
    a_r7_hold_until_result: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && div_busy) |=> (state_q == ST_HOLD));

    // R8: the coarse time only moves when a result is being started.
    a_r8_coarse_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(div_start) && $past(rst_n)) |-> $stable(out_coarse));
endmodule

// File: tb/sim_zcfd_timer.sv
module sim_zcfd_timer;
    localparam int DW = 14;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 in_valid;
    logic signed [DW-1:0] in_data;
    logic [31:0]          ts_count = '0;
    logic [3:0]           cfg_delay;
    logic [2:0]           cfg_shift;
    logic signed [DW-1:0] cfg_thresh;
    logic [7:0]           cfg_holdoff;
    logic                 out_valid;
    logic [31:0]          out_coarse;
    logic [7:0]           out_frac;

    int checks = 0, failures = 0, cyc = 0;
    int xs [64];
    int scyc [64];
    int got_n = 0, got_coarse [8], got_frac [8], got_cyc [8];
    int exp_n, exp_coarse [8], exp_frac [8], exp_cyc [8];
    bit done_flag = 0;

    zcfd_timer u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .ts_count(ts_count), .cfg_delay(cfg_delay), .cfg_shift(cfg_shift),
        .cfg_thresh(cfg_thresh), .cfg_holdoff(cfg_holdoff),
        .out_valid(out_valid), .out_coarse(out_coarse), .out_frac(out_frac)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) ts_count <= 32'(7000 + cyc);

    // Result monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (out_valid) begin
            if (got_n < 8) begin
                got_coarse[got_n] = int'(out_coarse);
                got_frac[got_n]   = int'(out_frac);
                got_cyc[got_n]    = cyc;
            end
            got_n = got_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    task automatic do_reset(input int d, input int sh, input int thr, input int h);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
        cfg_delay = 4'(d); cfg_shift = 3'(sh);
        cfg_thresh = DW'(thr); cfg_holdoff = 8'(h);
        repeat (3) @(negedge clk);
        got_n = 0;
        rst_n = 1'b1;
    endtask

    // Drive xs[0..n-1]; gap idle cycles carry junk with in_valid low (R9).
    task automatic feed(input int n, input int gap);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = DW'(xs[k]); scyc[k] = cyc;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                in_valid = 1'b0; in_data = DW'(3000);
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_data = '0;
        repeat (30) @(negedge clk);
    endtask

    // Expected events from the requirements, continuous samples only.
    task automatic model(input int n, input int d, input int sh, input int thr, input int h);
        int st = 0, zp = 0, hold_end = 0, zc, q;
        exp_n = 0;
        for (int k = 0; k < n; k++) begin
            zc = (xs[k] >>> sh) - ((k >= d) ? xs[k-d] : 0);
            if (st == 2 && k >= hold_end) st = 0;
            if (st != 2) begin
                if ((st == 1 || xs[k] > thr) && zp > 0 && zc <= 0) begin
                    q = (zp * 256) / (zp - zc);
                    if (q > 255) q = 255;
                    if (exp_n < 8) begin
                        exp_coarse[exp_n] = 7000 + scyc[k-1];
                        exp_frac[exp_n]   = q;
                        exp_cyc[exp_n]    = scyc[k] + 9;
                    end
                    exp_n++;
                    st = 2;
                    hold_end = k + ((h + 2 > 10) ? h + 2 : 10);
                end else if (st == 0 && xs[k] > thr) st = 1;
            end
            zp = zc;
        end
    endtask

    task automatic compare(input string req);
        chk(got_n == exp_n, {req, " count"}, got_n, exp_n);
        for (int i = 0; i < exp_n && i < 8 && i < got_n; i++) begin
            chk(got_coarse[i] == exp_coarse[i], {req, " R4 coarse"}, got_coarse[i], exp_coarse[i]);
            chk(got_frac[i] == exp_frac[i], {req, " R5 frac"}, got_frac[i], exp_frac[i]);
            chk(got_cyc[i] == exp_cyc[i], {req, " R5 latency"}, got_cyc[i], exp_cyc[i]);
        end
    endtask

    task automatic load_pulse(input int base, input int top2);
        int p [7] = '{40, 100, 160, 200, top2, 100, 40};
        for (int i = 0; i < 7; i++) xs[base+i] = p[i];
    endtask

    task automatic clear_xs();
        for (int i = 0; i < 64; i++) xs[i] = 0;
    endtask

    task automatic t_reset();
        do_reset(3, 1, 50, 4);
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 valid", int'(out_valid), 0);
        chk(out_coarse == 32'd0, "R8 coarse", int'(out_coarse), 0);
    endtask

    // R1 R2 R3 R4 R5: z1=60, z2=-20 gives 192.
    task automatic t_basic();
        clear_xs(); load_pulse(3, 160);
        do_reset(3, 1, 50, 4); feed(20, 0); model(20, 3, 1, 50, 4);
        compare("R1");
        chk(got_n == 1 && got_frac[0] == 192, "R5 hand frac", got_frac[0], 192);
        chk(got_n == 1 && got_coarse[0] == 7000 + scyc[6], "R4 hand coarse", got_coarse[0], 7000 + scyc[6]);
    endtask

    // R6: z2 = 0 saturates to 255.
    task automatic t_saturate();
        clear_xs(); load_pulse(3, 200);
        do_reset(3, 1, 50, 4); feed(20, 0); model(20, 3, 1, 50, 4);
        compare("R6");
        chk(got_n == 1 && got_frac[0] == 255, "R6 hand frac", got_frac[0], 255);
    endtask

    // R2: peak equals threshold, not strictly above; crossings ignored.
    task automatic t_below();
        int p [7] = '{10, 25, 40, 50, 40, 25, 10};
        clear_xs();
        for (int i = 0; i < 7; i++) xs[3+i] = p[i];
        do_reset(3, 1, 50, 4); feed(20, 0);
        chk(got_n == 0, "R2 no event below threshold", got_n, 0);
    endtask

    // R3: arming and crossing on the same sample, z1=5, z2=-5 gives 128.
    task automatic t_same_sample();
        clear_xs();
        xs[0] = 100; xs[1] = 10; xs[2] = 10; xs[3] = 190;
        do_reset(3, 1, 150, 0); feed(20, 0); model(20, 3, 1, 150, 0);
        compare("R3");
        chk(got_n == 1 && got_frac[0] == 128, "R3 hand frac", got_frac[0], 128);
        chk(got_n == 1 && got_coarse[0] == 7000 + scyc[2], "R3 hand coarse", got_coarse[0], 7000 + scyc[2]);
    endtask

    // R7: second pulse twelve samples later, three hold-off settings.
    task automatic t_holdoff(input int h, input int expect_n);
        clear_xs(); load_pulse(3, 160); load_pulse(15, 160);
        do_reset(3, 1, 50, h); feed(34, 0); model(34, 3, 1, 50, h);
        compare("R7");
        chk(got_n == expect_n, "R7 hand count", got_n, expect_n);
    endtask

    // R1: D=1, f=1/4; z1=75, z2=-125 gives 96.
    task automatic t_short_delay();
        clear_xs();
        xs[2] = 300; xs[3] = 700; xs[4] = 1000; xs[5] = 900; xs[6] = 600;
        do_reset(1, 2, 100, 0); feed(16, 0); model(16, 1, 2, 100, 0);
        compare("R1 short");
        chk(got_n == 1 && got_frac[0] == 96, "R1 hand frac", got_frac[0], 96);
    endtask

    // R9: idle cycles with junk data between samples change nothing.
    task automatic t_gaps();
        clear_xs(); load_pulse(3, 160);
        do_reset(3, 1, 50, 4); feed(14, 2);
        chk(got_n == 1, "R9 count", got_n, 1);
        chk(got_n == 1 && got_frac[0] == 192, "R9 frac", got_frac[0], 192);
        chk(got_n == 1 && got_coarse[0] == 7000 + scyc[6], "R9 coarse", got_coarse[0], 7000 + scyc[6]);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
        cfg_delay = 4'd3; cfg_shift = 3'd1; cfg_thresh = '0; cfg_holdoff = '0;
        t_reset();
        t_basic();
        t_saturate();
        t_below();
        t_same_sample();
        t_holdoff(30, 1);
        t_holdoff(2, 2);
        t_holdoff(10, 2);
        t_short_delay();
        t_gaps();
        finish_run();
    end
endmodule